// File: doc/BRIEF.md
# Mailbox Transmit Inbox Controller

This block is the sending half of an inter-core mailbox. A local processor, on a simple 32-bit register bus with byte offsets, stages a 64-bit message as a low word and a high word and picks one of eight target cores by ID. It then writes a commit register. The block keeps one message slot per target. It shows the slot contents and a busy indication to that target. The target takes the message with a one-cycle fetch pulse.

For each target the block tracks three flags: busy (a message is waiting and has not been fetched), delivered (the target has fetched a message) and overflow (a commit hit a slot that was still busy). The three flag vectors share one status word. Software clears delivered and overflow flags one by one through a clear register laid out in the same bit positions. A sticky pending flag records that something happened. The interrupt line asserts when that flag is set and at least one unmasked cause is present.

Top module: `mbox_tx_inbox`

## Requirements
- R1: After reset the status word (0x14) reads 0, the interrupt status (0x18) reads 0, the mask (0x1C) reads 0x7, `tgt_busy` is 0 and `irq` is low.
- R2: The ID (0x0), low word (0x4) and high word (0x8) registers read back what was written. A write of 1 in bit 0 of the commit register (0xC) copies {high, low} into the slot of the staged ID when that slot is idle, and sets the target's busy bit: status bits [7:0] and `tgt_busy`.
- R3: A commit to a target whose busy bit is set sets that target's overflow bit (status bits [15:8]) and leaves the stored message unchanged.
- R4: A fetch pulse on a busy target clears its busy bit and sets its delivered bit (status bits [23:16]). A fetch pulse on an idle target changes nothing.
- R5: A write to the clear register (0x10) clears exactly the delivered flags at 1 positions of bits [23:16] and the overflow flags at 1 positions of bits [15:8]. Busy bits are unaffected.
- R6: Mask register bit 0 masks the busy cause, bit 1 the overflow cause and bit 2 the delivered cause. A 1 means masked. The register reads back bits [2:0].
- R7: The pending flag (0x18 bit 0) is set by any accepted commit, overflow or delivery. Writing 1 to bit 0 clears it. Writing 0 has no effect.
- R8: `irq` is high exactly when the pending flag is set and an unmasked cause is active: any busy bit, any overflow bit or any delivered bit.
- R9: The lock register (0x20), the commit (0xC) and clear (0x10) registers and any unmapped offset read 0. The depth register (0x24) reads 0, meaning one slot entry per target. Writes to lock and unmapped offsets change no state.
- R10: A commit-register write with bit 0 clear queues nothing.
- R11: The ID register keeps only the low 3 bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tgt_fetch | input | 8 | Per-target fetch pulse |
| tgt_busy | output | 8 | Per-target message-waiting flag |
| tgt_data | output | 512 | Per-target 64-bit slot contents, target i at bits [64i+63:64i] |
| irq | output | 1 | Interrupt request |

## Verification
The bench commits to a target that is already busy. A design that overwrote the slot would change the data the target sees, and one that raised no overflow bit would leave software unaware that the message was lost. It pulses fetch on an idle target, where a careless design would invent a delivery and a spurious interrupt. It clears one overflow bit with a write that also covers busy positions. A design that cleared by register rather than by bit, or touched busy, shows the wrong status. It also exercises the mask against each cause separately, plus a commit write with bit 0 clear. A design that ignored the mask polarity or decoded the commit by address alone would mis-drive `irq` or queue a phantom message.

// File: rtl/mbox_tx_pkg.sv
package mbox_tx_pkg;
    localparam int AW    = 6;
    localparam int DW    = 32;
    localparam int NTGT  = 8;
    localparam int TW    = $clog2(NTGT);
    localparam int MSG_W = 2 * DW;
    localparam int DEPTH_M1 = 0;

    typedef logic [AW-1:0] addr_t;

    localparam addr_t OFS_ID    = 6'h00;
    localparam addr_t OFS_LO    = 6'h04;
    localparam addr_t OFS_HI    = 6'h08;
    localparam addr_t OFS_TRIG  = 6'h0C;
    localparam addr_t OFS_FRST  = 6'h10;
    localparam addr_t OFS_STAT  = 6'h14;
    localparam addr_t OFS_ISTS  = 6'h18;
    localparam addr_t OFS_IMSK  = 6'h1C;
    localparam addr_t OFS_LOCK  = 6'h20;
    localparam addr_t OFS_DEPTH = 6'h24;

    localparam int MSK_BLK = 0;
    localparam int MSK_OVF = 1;
    localparam int MSK_DLV = 2;

    typedef struct packed {
        logic trig;
        logic frst;
        logic isclr;
        logic imsk;
    } wstb_t;

    typedef struct packed {
        logic [TW-1:0] id;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } stage_t;

    typedef struct packed {
        logic             busy;
        logic             dlv;
        logic             ovf;
        logic [MSG_W-1:0] msg;
    } slot_t;

    typedef struct packed {
        logic       pend;
        logic [2:0] mask;
    } irq_state_t;
endpackage

// File: rtl/mbox_tx_regif.sv
module mbox_tx_regif
    import mbox_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  addr_t         bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] status_word,
    input  logic          pend,
    input  logic [2:0]    mask,
    output logic [TW-1:0] stg_id,
    output logic [DW-1:0] stg_lo,
    output logic [DW-1:0] stg_hi,
    output wstb_t         stb,
    output logic [DW-1:0] rdata
);
    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (bus_wr && bus_addr == OFS_ID) stage_d.id = bus_wdata[TW-1:0];
        if (bus_wr && bus_addr == OFS_LO) stage_d.lo = bus_wdata;
        if (bus_wr && bus_addr == OFS_HI) stage_d.hi = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    always_comb begin
        stb.trig  = bus_wr && (bus_addr == OFS_TRIG) && bus_wdata[0];
        stb.frst  = bus_wr && (bus_addr == OFS_FRST);
        stb.isclr = bus_wr && (bus_addr == OFS_ISTS) && bus_wdata[0];
        stb.imsk  = bus_wr && (bus_addr == OFS_IMSK);
    end

    always_comb begin
        rdata = '0;
        unique case (bus_addr)
            OFS_ID:    rdata = {{(DW-TW){1'b0}}, stage_q.id};
            OFS_LO:    rdata = stage_q.lo;
            OFS_HI:    rdata = stage_q.hi;
            OFS_STAT:  rdata = status_word;
            OFS_ISTS:  rdata = {{(DW-1){1'b0}}, pend};
            OFS_IMSK:  rdata = {{(DW-3){1'b0}}, mask};
            OFS_DEPTH: rdata = DW'(DEPTH_M1);
            default:   rdata = '0;
        endcase
    end

    assign stg_id = stage_q.id;
    assign stg_lo = stage_q.lo;
    assign stg_hi = stage_q.hi;
endmodule

// File: rtl/mbox_tx_slot.sv
module mbox_tx_slot
    import mbox_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq,
    input  logic [MSG_W-1:0] msg_in,
    input  logic             fetch,
    input  logic             clr_dlv,
    input  logic             clr_ovf,
    output logic             busy,
    output logic             dlv,
    output logic             ovf,
    output logic [MSG_W-1:0] msg_out,
    output logic             evt
);
    slot_t slot_d, slot_q;
    logic  acc, ovf_evt, dlv_evt;

    always_comb begin
        acc     = enq && !slot_q.busy;
        ovf_evt = enq && slot_q.busy;
        dlv_evt = fetch && slot_q.busy;
        slot_d  = slot_q;
        if (clr_dlv) slot_d.dlv = 1'b0;
        if (clr_ovf) slot_d.ovf = 1'b0;
        if (dlv_evt) begin
            slot_d.busy = 1'b0;
            slot_d.dlv  = 1'b1;
        end
        if (acc) begin
            slot_d.busy = 1'b1;
            slot_d.msg  = msg_in;
        end
        if (ovf_evt) slot_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign busy    = slot_q.busy;
    assign dlv     = slot_q.dlv;
    assign ovf     = slot_q.ovf;
    assign msg_out = slot_q.msg;
    assign evt     = acc || ovf_evt || dlv_evt;
endmodule

// File: rtl/mbox_tx_irq.sv
module mbox_tx_irq
    import mbox_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_mask,
    input  logic [2:0] mask_in,
    input  logic       clr_pend,
    input  logic       any_evt,
    input  logic       c_busy,
    input  logic       c_ovf,
    input  logic       c_dlv,
    output logic       pend,
    output logic [2:0] mask,
    output logic       irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask)  st_d.mask = mask_in;
        if (clr_pend) st_d.pend = 1'b0;
        if (any_evt)  st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 1'b0, mask: 3'b111};
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign mask = st_q.mask;
    assign irq  = st_q.pend && ((c_busy && !st_q.mask[MSK_BLK]) ||
                                (c_ovf  && !st_q.mask[MSK_OVF]) ||
                                (c_dlv  && !st_q.mask[MSK_DLV]));
endmodule

// File: rtl/mbox_tx_inbox.sv
module mbox_tx_inbox
    import mbox_tx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [NTGT-1:0]       tgt_fetch,
    output logic [NTGT-1:0]       tgt_busy,
    output logic [NTGT*MSG_W-1:0] tgt_data,
    output logic                  irq
);
    logic [TW-1:0]   stg_id;
    logic [DW-1:0]   stg_lo, stg_hi;
    wstb_t           stb;
    logic [NTGT-1:0] busy_v, dlv_v, ovf_v, evt_v;
    logic [DW-1:0]   status_word;
    logic            irq_pend;
    logic [2:0]      irq_mask;

    assign status_word = {{(DW-3*NTGT){1'b0}}, dlv_v, ovf_v, busy_v};

    mbox_tx_regif u_regif (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status_word(status_word), .pend(irq_pend),
        .mask(irq_mask), .stg_id(stg_id), .stg_lo(stg_lo), .stg_hi(stg_hi),
        .stb(stb), .rdata(bus_rdata)
    );

    for (genvar i = 0; i < NTGT; i++) begin : g_slot
        mbox_tx_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .enq(stb.trig && (stg_id == TW'(i))),
            .msg_in({stg_hi, stg_lo}),
            .fetch(tgt_fetch[i]),
            .clr_dlv(stb.frst && bus_wdata[2*NTGT+i]),
            .clr_ovf(stb.frst && bus_wdata[NTGT+i]),
            .busy(busy_v[i]), .dlv(dlv_v[i]), .ovf(ovf_v[i]),
            .msg_out(tgt_data[i*MSG_W +: MSG_W]),
            .evt(evt_v[i])
        );
    end

    mbox_tx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .wr_mask(stb.imsk), .mask_in(bus_wdata[2:0]),
        .clr_pend(stb.isclr), .any_evt(|evt_v), .c_busy(|busy_v),
        .c_ovf(|ovf_v), .c_dlv(|dlv_v), .pend(irq_pend), .mask(irq_mask),
        .irq(irq)
    );

    assign tgt_busy = busy_v;
endmodule

// File: rtl/mbox_tx_inbox_chk.sv
module mbox_tx_inbox_chk
    import mbox_tx_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic                  trig_bit,
    input logic [NTGT-1:0]       tgt_fetch,
    input logic [NTGT-1:0]       tgt_busy,
    input logic [NTGT*MSG_W-1:0] tgt_data,
    input logic                  irq,
    input logic                  pend
);
    // R4: a fetched busy target is idle on the next cycle
    p_fetch_idles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_fetch & tgt_busy) != '0 |=> (tgt_busy & $past(tgt_fetch & tgt_busy)) == '0);

    // R2: busy only rises after a commit write with bit 0 set
    p_busy_needs_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_busy & ~$past(tgt_busy)) != '0 |-> $past(bus_wr && bus_addr == OFS_TRIG && trig_bit));

    // R8: interrupt never without the pending flag
    p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend);

    // R7: a delivery raises the pending flag
    p_dlv_sets_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_fetch & tgt_busy) != '0 |=> pend);

    // R3: a waiting message is never altered before its fetch
    for (genvar i = 0; i < NTGT; i++) begin : g_hold
        p_hold_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_busy[i] && !tgt_fetch[i]) |=> $stable(tgt_data[i*MSG_W +: MSG_W]));
    end
endmodule

bind mbox_tx_inbox mbox_tx_inbox_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .trig_bit(bus_wdata[0]), .tgt_fetch(tgt_fetch), .tgt_busy(tgt_busy),
    .tgt_data(tgt_data), .irq(irq), .pend(irq_pend)
);

// File: tb/mbox_tx_inbox_bench.sv
module mbox_tx_inbox_bench;
    import mbox_tx_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_wr = 1'b0;
    logic [AW-1:0]         bus_addr = '0;
    logic [DW-1:0]         bus_wdata = '0;
    logic [DW-1:0]         bus_rdata;
    logic [NTGT-1:0]       tgt_fetch = '0;
    logic [NTGT-1:0]       tgt_busy;
    logic [NTGT*MSG_W-1:0] tgt_data;
    logic                  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mbox_tx_inbox u_mbox_tx_inbox (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_fetch(tgt_fetch),
        .tgt_busy(tgt_busy), .tgt_data(tgt_data), .irq(irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_FT = 2'd2, OP_IQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        addr_t       addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{OP_WR, OFS_ID,    32'h3,         32'h0,         8'd2},
        '{OP_WR, OFS_LO,    32'h1111_2222, 32'h0,         8'd2},
        '{OP_WR, OFS_HI,    32'hAAAA_BBBB, 32'h0,         8'd2},
        '{OP_RD, OFS_ID,    32'h0,         32'h3,         8'd2},  // R2
        '{OP_RD, OFS_LO,    32'h0,         32'h1111_2222, 8'd2},
        '{OP_RD, OFS_HI,    32'h0,         32'hAAAA_BBBB, 8'd2},
        '{OP_WR, OFS_TRIG,  32'h1,         32'h0,         8'd2},
        '{OP_RD, OFS_STAT,  32'h0,         32'h0000_0008, 8'd2},
        '{OP_RD, OFS_ISTS,  32'h0,         32'h1,         8'd7},  // R7
        '{OP_IQ, OFS_ID,    32'h0,         32'h0,         8'd8},  // R8 all masked
        '{OP_WR, OFS_IMSK,  32'h6,         32'h0,         8'd6},
        '{OP_RD, OFS_IMSK,  32'h0,         32'h6,         8'd6},  // R6
        '{OP_IQ, OFS_ID,    32'h0,         32'h1,         8'd8},
        '{OP_WR, OFS_LO,    32'h5555_5555, 32'h0,         8'd3},
        '{OP_WR, OFS_TRIG,  32'h1,         32'h0,         8'd3},
        '{OP_RD, OFS_STAT,  32'h0,         32'h0000_0808, 8'd3},  // R3
        '{OP_FT, OFS_ID,    32'h08,        32'h0,         8'd4},
        '{OP_RD, OFS_STAT,  32'h0,         32'h0008_0800, 8'd4},  // R4
        '{OP_FT, OFS_ID,    32'h01,        32'h0,         8'd4},
        '{OP_RD, OFS_STAT,  32'h0,         32'h0008_0800, 8'd4},
        '{OP_WR, OFS_FRST,  32'h0000_0800, 32'h0,         8'd5},
        '{OP_RD, OFS_STAT,  32'h0,         32'h0008_0000, 8'd5},  // R5
        '{OP_WR, OFS_ISTS,  32'h0,         32'h0,         8'd7},
        '{OP_RD, OFS_ISTS,  32'h0,         32'h1,         8'd7},
        '{OP_WR, OFS_ISTS,  32'h1,         32'h0,         8'd7},
        '{OP_RD, OFS_ISTS,  32'h0,         32'h0,         8'd7},
        '{OP_IQ, OFS_ID,    32'h0,         32'h0,         8'd8},
        '{OP_WR, OFS_LOCK,  32'hFFFF_FFFF, 32'h0,         8'd9},
        '{OP_RD, OFS_LOCK,  32'h0,         32'h0,         8'd9},  // R9
        '{OP_RD, OFS_DEPTH, 32'h0,         32'h0,         8'd9},
        '{OP_RD, OFS_TRIG,  32'h0,         32'h0,         8'd9},
        '{OP_RD, 6'h28,     32'h0,         32'h0,         8'd9},
        '{OP_RD, OFS_STAT,  32'h0,         32'h0008_0000, 8'd9},
        '{OP_WR, OFS_TRIG,  32'h0,         32'h0,         8'd10},
        '{OP_RD, OFS_STAT,  32'h0,         32'h0008_0000, 8'd10}, // R10
        '{OP_WR, OFS_ID,    32'hFF,        32'h0,         8'd11},
        '{OP_RD, OFS_ID,    32'h0,         32'h7,         8'd11}  // R11
    };

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input int req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input addr_t a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input addr_t a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic fetch(input logic [NTGT-1:0] m);
        @(negedge clk);
        tgt_fetch = m;
        @(negedge clk);
        tgt_fetch = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset values
        rd(OFS_STAT, v); check(64'(v), 64'h0, 1);
        rd(OFS_ISTS, v); check(64'(v), 64'h0, 1);
        rd(OFS_IMSK, v); check(64'(v), 64'h7, 1);
        check(64'(tgt_busy), 64'h0, 1);
        check(64'(irq), 64'h0, 1);
        @(negedge clk); rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                OP_WR: wr(VECS[k].addr, VECS[k].data);
                OP_FT: fetch(VECS[k].data[NTGT-1:0]);
                OP_RD: begin
                    rd(VECS[k].addr, v);
                    check(64'(v), 64'(VECS[k].exp), int'(VECS[k].req));
                end
                default: begin
                    #1;
                    check(64'(irq), 64'(VECS[k].exp), int'(VECS[k].req));
                end
            endcase
        end

        // R3: slot 3 still holds the first message after the rejected commit
        check(tgt_data[3*MSG_W +: MSG_W], 64'hAAAA_BBBB_1111_2222, 3);

        // R5: clear-all write leaves busy in place (ID is now 7)
        wr(OFS_TRIG, 32'h1);
        check(64'(tgt_busy), 64'h80, 2);
        wr(OFS_FRST, 32'h00FF_FFFF);
        rd(OFS_STAT, v); check(64'(v), 64'h0000_0080, 5);

        // R8: overflow cause alone drives irq when unmasked
        wr(OFS_IMSK, 32'h7);
        wr(OFS_ISTS, 32'h1);
        wr(OFS_TRIG, 32'h1);
        rd(OFS_STAT, v); check(64'(v), 64'h0000_8080, 3);
        check(64'(irq), 64'h0, 8);
        wr(OFS_IMSK, 32'h5);
        #1; check(64'(irq), 64'h1, 8);
        wr(OFS_IMSK, 32'h3);
        #1; check(64'(irq), 64'h0, 8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule